// File: doc/BRIEF.md
# Reset Supervisor with Filtered Fault Monitors

This block creates the system reset for a chip that shares one open-drain reset line with other devices. Five digital fault flags come from the supply and temperature comparators. Each flag must stay present for a minimum number of clock cycles before it counts. While any fault counts, the block pulls the shared line low. After every fault has gone away, it keeps pulling for a further hold period and then lets go.

The block also reads the line back through its pad input. If another device pulls the line low while the system is running, the supervisor takes over at once with a registered pull-down and runs a complete hold period. The pull-up on an open-drain line is slow. For that reason the pad input is ignored for a blanking window after each release. The internal reset stays asserted through that window and is removed only once the window ends.

All three times are parameters counted in clock cycles: `FILT_CYC` for the fault filter, `HOLD_CYC` for the hold period and `BLANK_CYC` for the blanking window.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `pull_en` and `sys_rst` are both 1.
- R2: If a fault flag is high when `rst` is released, `pull_en` stays 1 for as long as that flag stays high.
- R3: The flag bits are mapped as follows: bit 0 is 5 V low, bit 1 is 3.3 V low, bit 2 is core supply low, bit 3 is battery low and bit 4 is over-temperature. Suppose any one bit goes high while the system runs and stays high. Then `pull_en` becomes 1 after the flag has been sampled high on `FILT_CYC` consecutive clock edges, at the next edge.
- R4: A flag that drops before it has been sampled high on `FILT_CYC` consecutive edges restarts its filter. It causes no reset, even when it is repeated with a one-cycle gap.
- R5: `pull_en` returns to 0 exactly `HOLD_CYC` clock edges after the last edge at which any raw flag was high. A flag pulse during the hold period, even a single cycle long, restarts that count.
- R6: When the system is running and `pad_in` is sampled 0, `pull_en` is 1 after the next clock edge. The release then follows `HOLD_CYC` edges after the pull-down began.
- R7: After `pull_en` returns to 0, `pad_in` is ignored for `BLANK_CYC` edges. During that time `pull_en` stays 0. `sys_rst` falls at the end of this window.
- R8: `sys_rst` is 1 whenever `pull_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the supervisor logic |
| fault_flags | input | 5 | Raw fault flags, active high (bit mapping in R3) |
| pad_in | input | 1 | Sampled level of the shared reset line (1 = high) |
| pull_en | output | 1 | Registered enable for the open-drain pull-down |
| sys_rst | output | 1 | Registered internal reset, active high |

## Verification
A wrong internal state shows up mainly as a shift in edge timing on `pull_en` or `sys_rst`. A filter counter that is off by one moves the assertion edge by one cycle. A hold timer that fails to restart releases the line early, and this appears within `HOLD_CYC` cycles of the last fault. A blanking window that is missing or too short lets the slowly rising line start a new reset. That second pull-down appears within a few cycles of the release. For these reasons the bench counts the exact number of cycles to each edge, and it watches the line for some time after each release.

// File: rtl/rsup_pkg.sv
package rsup_pkg;

    localparam int FAULT_SRCS = 5;

    // Bit positions inside the fault flag vector
    localparam int SRC_V5    = 0;
    localparam int SRC_V33   = 1;
    localparam int SRC_CORE  = 2;
    localparam int SRC_BATT  = 3;
    localparam int SRC_THERM = 4;

    typedef enum logic [1:0] {
        PH_HOLD  = 2'b00,
        PH_BLANK = 2'b01,
        PH_RUN   = 2'b10
    } phase_e;

    typedef struct packed {
        logic pull;
        logic sys;
    } rst_drive_s;

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rsup_fault_filter.sv
module rsup_fault_filter #(
    parameter int unsigned FILT_CYC = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic flag_i,
    output logic filt_o
);
    localparam int unsigned W = rsup_pkg::cnt_width(FILT_CYC);
    localparam logic [W-1:0] FULL = W'(FILT_CYC);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (!flag_i)
            cnt_q <= '0;
        else if (cnt_q != FULL)
            cnt_q <= cnt_q + 1'b1;
    end

    assign filt_o = (cnt_q == FULL);

    assert_short_fault_no_reset_R4: assert property (@(posedge clk) disable iff (rst)
        !flag_i |=> !filt_o);

    assert_filter_history_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(filt_o) |-> $past(flag_i));

endmodule

// File: rtl/rsup_phase_timer.sv
module rsup_phase_timer #(
    parameter int unsigned MAX_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic en_i,
    input  logic [rsup_pkg::cnt_width(MAX_CYC)-1:0] last_i,
    output logic done_o
);
    localparam int unsigned W = rsup_pkg::cnt_width(MAX_CYC);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)
            cnt_q <= '0;
        else if (en_i)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done_o = (cnt_q == last_i);

    assert_timer_bounded_R5: assert property (@(posedge clk) disable iff (rst)
        en_i |=> (cnt_q <= W'(MAX_CYC)));

endmodule

// File: rtl/rsup_sequencer.sv
module rsup_sequencer #(
    parameter int unsigned HOLD_CYC  = 64,
    parameter int unsigned BLANK_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic any_raw_i,
    input  logic any_filt_i,
    input  logic pad_in,
    output logic pull_en_o,
    output logic sys_rst_o
);
    import rsup_pkg::*;

    localparam int unsigned TMAX = max_u(HOLD_CYC, BLANK_CYC);
    localparam int unsigned TW   = cnt_width(TMAX);
    localparam logic [TW-1:0] HOLD_LAST  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] BLANK_LAST = TW'(BLANK_CYC - 1);

    phase_e     phase_q, phase_d;
    rst_drive_s drv_q, drv_d;
    logic       t_clr, t_en, t_done;
    logic [TW-1:0] t_last;

    assign t_last = (phase_q == PH_HOLD) ? HOLD_LAST : BLANK_LAST;

    rsup_phase_timer #(.MAX_CYC(TMAX)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (t_clr),
        .en_i   (t_en),
        .last_i (t_last),
        .done_o (t_done)
    );

    always_comb begin
        phase_d = phase_q;
        t_clr   = 1'b0;
        t_en    = 1'b0;
        unique case (phase_q)
            PH_HOLD: begin
                if (any_raw_i) begin
                    t_clr = 1'b1;
                end else if (t_done) begin
                    phase_d = PH_BLANK;
                    t_clr   = 1'b1;
                end else begin
                    t_en = 1'b1;
                end
            end
            PH_BLANK: begin
                if (any_filt_i) begin
                    phase_d = PH_HOLD;
                    t_clr   = 1'b1;
                end else if (t_done) begin
                    phase_d = PH_RUN;
                    t_clr   = 1'b1;
                end else begin
                    t_en = 1'b1;
                end
            end
            PH_RUN: begin
                if (any_filt_i || !pad_in) begin
                    phase_d = PH_HOLD;
                    t_clr   = 1'b1;
                end
            end
            default: begin
                phase_d = PH_HOLD;
                t_clr   = 1'b1;
            end
        endcase
        drv_d.pull = (phase_d == PH_HOLD);
        drv_d.sys  = (phase_d != PH_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HOLD;
            drv_q   <= '{pull: 1'b1, sys: 1'b1};
        end else begin
            phase_q <= phase_d;
            drv_q   <= drv_d;
        end
    end

    assign pull_en_o = drv_q.pull;
    assign sys_rst_o = drv_q.sys;

    assert_ext_fast_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_RUN && !pad_in) |=> pull_en_o);

    assert_internal_covers_line_R8: assert property (@(posedge clk) disable iff (rst)
        pull_en_o |-> sys_rst_o);

    assert_release_fault_free_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(pull_en_o) |-> !$past(any_raw_i));

    assert_blank_ignores_pad_R7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_BLANK && !any_filt_i) |=> !pull_en_o);

    assert_fault_keeps_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_HOLD && any_raw_i) |=> pull_en_o);

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int unsigned FILT_CYC  = 16,
    parameter int unsigned HOLD_CYC  = 64,
    parameter int unsigned BLANK_CYC = 8
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [rsup_pkg::FAULT_SRCS-1:0] fault_flags,
    input  logic                            pad_in,
    output logic                            pull_en,
    output logic                            sys_rst
);
    localparam int unsigned NSRC = rsup_pkg::FAULT_SRCS;

    logic [NSRC-1:0] filt;

    for (genvar g = 0; g < NSRC; g++) begin : g_filter
        rsup_fault_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .flag_i (fault_flags[g]),
            .filt_o (filt[g])
        );
    end

    rsup_sequencer #(
        .HOLD_CYC  (HOLD_CYC),
        .BLANK_CYC (BLANK_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .any_raw_i  (|fault_flags),
        .any_filt_i (|filt),
        .pad_in     (pad_in),
        .pull_en_o  (pull_en),
        .sys_rst_o  (sys_rst)
    );

endmodule

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;
    localparam int FILT  = 16;
    localparam int HOLD  = 64;
    localparam int BLANK = 8;
    localparam int RISE  = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] fault_flags = '0;
    logic       ext_low = 1'b0;
    logic       pad_in;
    logic       pull_en, sys_rst;
    int         lo_cnt = 0;
    int         tests = 0;
    int         fails = 0;
    int         cyc = 0;

    always #10 clk = ~clk;

    // Wired line with a slow rise after every low
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pull_en || ext_low) lo_cnt <= RISE;
        else if (lo_cnt != 0)   lo_cnt <= lo_cnt - 1;
    end
    assign pad_in = !(pull_en || ext_low || (lo_cnt != 0));

    rst_supervisor #(.FILT_CYC(FILT), .HOLD_CYC(HOLD), .BLANK_CYC(BLANK)) uut (
        .clk(clk), .rst(rst), .fault_flags(fault_flags), .pad_in(pad_in),
        .pull_en(pull_en), .sys_rst(sys_rst)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Negedges until the chosen output (0 = pull_en, 1 = sys_rst) equals val
    task automatic cycles_to(input int which, input logic val, input int lim, output int n);
        n = 0;
        while (n < lim) begin
            @(negedge clk);
            n++;
            if (((which == 0) ? pull_en : sys_rst) == val) break;
        end
    endtask

    task automatic to_run();
        int n;
        cycles_to(1, 1'b0, 500, n);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset_powerup();
        int n;
        fault_flags[rsup_pkg::SRC_CORE] = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 pull_en in reset", pull_en, 1);
        check("R1 sys_rst in reset", sys_rst, 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 pull_en after reset", pull_en, 1);
        repeat (40) @(negedge clk);
        check("R2 pull held with fault", pull_en, 1);
        fault_flags = '0;
        cycles_to(0, 1'b0, 500, n);
        check("R5 hold after power-up", n, HOLD);
    endtask

    task automatic t_blank();
        int n = 0;
        int pulls = 0;
        while (n < 100 && sys_rst) begin
            @(negedge clk);
            n++;
            if (pull_en) pulls++;
        end
        check("R7 sys_rst release delay", n, BLANK);
        check("R7 no pull during blanking", pulls, 0);
        repeat (20) @(negedge clk);
        check("R7 line quiet after blanking", pull_en, 0);
        check("R7 sys_rst stays low", sys_rst, 0);
    endtask

    task automatic t_filter_each();
        int n;
        for (int s = 0; s < 5; s++) begin
            fault_flags[s] = 1'b1;
            cycles_to(0, 1'b1, 200, n);
            check($sformatf("R3 filter delay source %0d", s), n, FILT + 1);
            check("R8 sys_rst with pull", sys_rst, 1);
            fault_flags = '0;
            to_run();
        end
    endtask

    task automatic t_short();
        int pulls = 0;
        fault_flags[rsup_pkg::SRC_V33] = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        fault_flags = '0;
        @(negedge clk);
        fault_flags[rsup_pkg::SRC_THERM] = 1'b1;
        repeat (FILT - 1) @(negedge clk);
        fault_flags = '0;
        for (int i = 0; i < 3 * FILT; i++) begin
            @(negedge clk);
            if (pull_en) pulls++;
        end
        check("R4 short faults ignored", pulls, 0);
    endtask

    task automatic t_hold_restart();
        int n;
        fault_flags[rsup_pkg::SRC_BATT] = 1'b1;
        repeat (FILT + 10) @(negedge clk);
        check("R3 battery fault pulls", pull_en, 1);
        fault_flags = '0;
        repeat (20) @(negedge clk);
        fault_flags[rsup_pkg::SRC_V5] = 1'b1;
        @(negedge clk);
        fault_flags = '0;
        cycles_to(0, 1'b0, 500, n);
        check("R5 hold restarted by pulse", n, HOLD);
        to_run();
    endtask

    task automatic t_ext();
        int n;
        ext_low = 1'b1;
        cycles_to(0, 1'b1, 20, n);
        check("R6 external low response", n, 1);
        check("R8 sys_rst on external", sys_rst, 1);
        repeat (10) @(negedge clk);
        ext_low = 1'b0;
        cycles_to(0, 1'b0, 500, n);
        check("R6 hold after external low", n, HOLD - 10);
        t_blank();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        t_reset_powerup();
        t_blank();
        t_filter_each();
        t_short();
        t_hold_restart();
        t_ext();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule